// File: doc/BRIEF.md
# Hashed Micro-Tag Way Predictor

This block guesses which way of an 8-way set-associative L1 data cache holds a requested line, so that only one way's data array has to be read. It keeps an 8-bit micro-tag and a valid flag for every way of every set. The micro-tag is a hash of virtual-address bits 12 to 27 built from a single level of two-input XOR gates. The set index comes from address bits below 12, so the table read can start before the hash is ready. A lookup compares the hashed key with the stored micro-tags of all ways in the indexed set. The result, a hit flag and a binary way number, is registered and appears one cycle after the address is presented.

The fill port names a set, the address being installed and the replacement victim proposed by the cache's LRU logic. It returns the way actually written. If a valid way in that set already carries the same micro-tag, that way is overwritten in place of the LRU victim, so no set ever holds two valid copies of one micro-tag. A synchronous flush clears every valid flag in one cycle. The physical tag check, address translation and data arrays sit outside this block.

Top module: `way_predictor`

## Requirements
- R1: Micro-tag bit k, for k = 0..7, is VA[12+k] XOR VA[p(k)], with p = 27, 26, 25, 20, 21, 22, 23, 24 for k = 0..7. Two addresses with equal micro-tags are indistinguishable to the predictor.
- R2: When `lk_valid` is high and a valid way in set VA[11:6] holds the key's micro-tag, then after the next rising edge `pred_hit` is 1 and `pred_way` gives that way as a binary number.
- R3: When no valid way of the indexed set matches, `pred_hit` is 0 after the next edge and `pred_way` is 0. This is reported as a miss.
- R4: The set index is VA[11:6]. An entry installed in one set never produces a hit for a lookup that indexes another set.
- R5: On a fill with no valid matching micro-tag in `fill_set`, `fill_way` equals `fill_lru_way` in the same cycle. That way is written valid with the fill address's micro-tag at the next edge.
- R6: On a fill where a valid way in `fill_set` already holds the fill micro-tag, `fill_way` is that way regardless of `fill_lru_way`, and that way is rewritten.
- R7: No set ever holds two valid ways with the same micro-tag.
- R8: `flush` clears every valid flag at the next edge and takes priority over a fill in the same cycle.
- R9: When `lk_valid` is low, `pred_hit` and `pred_way` are 0 after the next edge.
- R10: After reset, all entries are invalid and `pred_hit` is 0.
- R11: A lookup presented in the same cycle as a fill or flush sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Lookup virtual address |
| pred_hit | output | 1 | Registered prediction valid |
| pred_way | output | 3 | Registered predicted way |
| fill_en | input | 1 | Fill request |
| fill_set | input | 6 | Set being filled |
| fill_vaddr | input | 48 | Virtual address being installed |
| fill_lru_way | input | 3 | Victim proposed by LRU |
| fill_way | output | 3 | Way chosen for the fill |

## Verification
Assertions check on every cycle that each set's match vector is at most one-hot (R7). They also check that a flush leaves no valid entry (R8), that a fill marks its chosen way valid (R5, R6), and that an idle lookup cycle yields no hit (R9). The exact hash bit pairing, the override of the LRU victim, the separation between sets, and the old-contents view of a lookup that collides with a write can only be shown by the bench's scenarios. The bench compares these against a reference model of the table.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int UT_W   = 8;
  localparam int HASH_BASE = 12;
  localparam int HASH_SPAN = 16;

  // low operand of micro-tag bit k, relative to HASH_BASE
  function automatic int lo_bit(input int k);
    return k;
  endfunction

  // high operand of micro-tag bit k, relative to HASH_BASE
  function automatic int hi_bit(input int k);
    return (k < 3) ? (15 - k) : (5 + k);
  endfunction
endpackage

// File: rtl/utag_hash.sv
module utag_hash
  import wp_pkg::*;
(
  input  logic [HASH_SPAN-1:0] va_mid,
  output logic [UT_W-1:0]      utag
);
  for (genvar k = 0; k < UT_W; k++) begin : g_xor
    localparam int LO = lo_bit(k);
    localparam int HI = hi_bit(k);
    assign utag[k] = va_mid[LO] ^ va_mid[HI];
  end
endmodule

// File: rtl/utag_store.sv
module utag_store
  import wp_pkg::*;
#(
  parameter int SETS = 64,
  parameter int WAYS = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [UT_W-1:0]  wr_tag,
  input  logic [SET_W-1:0] rd_set_a,
  output logic [UT_W-1:0]  rd_tags_a [WAYS],
  output logic [WAYS-1:0]  rd_val_a,
  input  logic [SET_W-1:0] rd_set_b,
  output logic [UT_W-1:0]  rd_tags_b [WAYS],
  output logic [WAYS-1:0]  rd_val_b
);
  logic [UT_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0] val_q [SETS];
  logic [WAYS-1:0] val_d [SETS];
  logic            tag_we;

  assign tag_we = wr_en && !flush;

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      val_d[s] = flush ? '0 : val_q[s];
    end
    if (tag_we) val_d[wr_set][wr_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) val_q[s] <= val_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[wr_set][wr_way] <= wr_tag;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tags_a[w] = tag_q[rd_set_a][w];
      rd_tags_b[w] = tag_q[rd_set_b][w];
    end
    rd_val_a = val_q[rd_set_a];
    rd_val_b = val_q[rd_set_b];
  end

  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|val_q[s]);
  end

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_valid);

  // R5
  fill_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> val_q[$past(wr_set)][$past(wr_way)]);
endmodule

// File: rtl/utag_match.sv
module utag_match
  import wp_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UT_W-1:0]  key,
  input  logic [UT_W-1:0]  tags [WAYS],
  input  logic [WAYS-1:0]  valid,
  output logic             hit,
  output logic [WAY_W-1:0] way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid[w] && (tags[w] == key);
  end

  assign hit = |eq;

  always_comb begin
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (eq[w]) way = way | WAY_W'(w);
    end
  end

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eq));
endmodule

// File: rtl/way_predictor.sv
module way_predictor
  import wp_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int SETS   = 64,
  parameter int WAYS   = 8,
  parameter int LINE_B = 64,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             pred_hit,
  output logic [WAY_W-1:0] pred_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [VA_W-1:0]  fill_vaddr,
  input  logic [WAY_W-1:0] fill_lru_way,
  output logic [WAY_W-1:0] fill_way
);
  logic [SET_W-1:0] lk_set;
  logic [UT_W-1:0]  lk_key, fl_key;
  logic [UT_W-1:0]  tags_a [WAYS];
  logic [UT_W-1:0]  tags_b [WAYS];
  logic [WAYS-1:0]  val_a, val_b;
  logic             lk_hit, fl_hit;
  logic [WAY_W-1:0] lk_way, fl_way;
  logic             pred_hit_d;
  logic [WAY_W-1:0] pred_way_d;
  logic             unused_bits;

  assign lk_set = lk_vaddr[OFF_W +: SET_W];
  assign unused_bits = ^{lk_vaddr[11:0], lk_vaddr[VA_W-1:28],
                         fill_vaddr[11:0], fill_vaddr[VA_W-1:28]};

  utag_hash u_hash_lk (.va_mid(lk_vaddr[HASH_BASE +: HASH_SPAN]),   .utag(lk_key));
  utag_hash u_hash_fl (.va_mid(fill_vaddr[HASH_BASE +: HASH_SPAN]), .utag(fl_key));

  utag_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(fill_en), .wr_set(fill_set), .wr_way(fill_way), .wr_tag(fl_key),
    .rd_set_a(lk_set),   .rd_tags_a(tags_a), .rd_val_a(val_a),
    .rd_set_b(fill_set), .rd_tags_b(tags_b), .rd_val_b(val_b)
  );

  utag_match #(.WAYS(WAYS)) u_match_lk (
    .clk(clk), .rst_n(rst_n), .key(lk_key), .tags(tags_a), .valid(val_a),
    .hit(lk_hit), .way(lk_way)
  );

  utag_match #(.WAYS(WAYS)) u_match_fl (
    .clk(clk), .rst_n(rst_n), .key(fl_key), .tags(tags_b), .valid(val_b),
    .hit(fl_hit), .way(fl_way)
  );

  // matching way wins over the LRU victim
  assign fill_way = fl_hit ? fl_way : fill_lru_way;

  always_comb begin
    pred_hit_d = lk_valid && lk_hit;
    pred_way_d = pred_hit_d ? lk_way : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_hit <= 1'b0;
      pred_way <= '0;
    end else begin
      pred_hit <= pred_hit_d;
      pred_way <= pred_way_d;
    end
  end

  // R9
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!pred_hit && pred_way == '0));

  // R3
  miss_way_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> pred_way == '0);
endmodule

// File: tb/way_predictor_bench.sv
module way_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic        pred_hit;
  logic [2:0]  pred_way;
  logic        fill_en = 1'b0;
  logic [5:0]  fill_set = '0;
  logic [47:0] fill_vaddr = '0;
  logic [2:0]  fill_lru_way = '0;
  logic [2:0]  fill_way;

  always #4 clk = ~clk;

  way_predictor u_way_predictor (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .pred_hit(pred_hit), .pred_way(pred_way),
    .fill_en(fill_en), .fill_set(fill_set), .fill_vaddr(fill_vaddr),
    .fill_lru_way(fill_lru_way), .fill_way(fill_way)
  );

  typedef struct { bit hit; bit [2:0] way; string req; } exp_t;
  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  bit [7:0] m_tag [64][8];
  bit       m_val [64][8];

  function automatic bit [7:0] ref_hash(input bit [47:0] a);
    bit [7:0] h;
    h[0] = a[12] ^ a[27]; h[1] = a[13] ^ a[26];
    h[2] = a[14] ^ a[25]; h[3] = a[15] ^ a[20];
    h[4] = a[16] ^ a[21]; h[5] = a[17] ^ a[22];
    h[6] = a[18] ^ a[23]; h[7] = a[19] ^ a[24];
    return h;
  endfunction

  function automatic bit [47:0] mk_addr(input bit [15:0] mid, input bit [5:0] set);
    return {20'h0, mid, set, 6'h0};
  endfunction

  task automatic report_end();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // one cycle of stimulus; expected lookup result goes to the scoreboard
  task automatic step(input bit lv, input bit [47:0] la,
                      input bit fe, input bit [5:0] fs, input bit [47:0] fa,
                      input bit [2:0] lru, input bit fl, input string req);
    exp_t e;
    bit [7:0] k;
    bit [2:0] fw;
    bit fh;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = la; fill_en = fe; fill_set = fs;
    fill_vaddr = fa; fill_lru_way = lru; flush = fl;
    // R11: expectation from contents before this cycle's write
    e.hit = 1'b0; e.way = 3'd0; e.req = req;
    if (lv) begin
      k = ref_hash(la);
      for (int w = 0; w < 8; w++)
        if (m_val[la[11:6]][w] && m_tag[la[11:6]][w] == k) begin
          e.hit = 1'b1; e.way = 3'(w);
        end
    end
    exp_q.push_back(e);
    if (fe) begin
      k = ref_hash(fa);
      fh = 1'b0; fw = lru;
      for (int w = 0; w < 8; w++)
        if (m_val[fs][w] && m_tag[fs][w] == k) begin fh = 1'b1; fw = 3'(w); end
      #1;
      n_cmp++;
      if (fill_way !== fw) begin
        n_bad++;
        $display("FAIL %s fill_way: got %0d expected %0d", fh ? "R6" : "R5", fill_way, fw);
      end
      if (!fl) begin m_tag[fs][fw] = k; m_val[fs][fw] = 1'b1; end
    end
    if (fl) for (int s = 0; s < 64; s++) for (int w = 0; w < 8; w++) m_val[s][w] = 1'b0;
  endtask

  task automatic look(input bit [47:0] a, input string req);
    step(1'b1, a, 1'b0, 6'd0, 48'd0, 3'd0, 1'b0, req);
  endtask

  task automatic fill(input bit [5:0] s, input bit [47:0] a, input bit [2:0] lru, input string req);
    step(1'b0, 48'd0, 1'b1, s, a, lru, 1'b0, req);
  endtask

  // monitor: compares registered prediction after each edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_cmp++;
      if (pred_hit !== e.hit || pred_way !== e.way) begin
        n_bad++;
        $display("FAIL %s lookup: got hit=%0b way=%0d expected hit=%0b way=%0d",
                 e.req, pred_hit, pred_way, e.hit, e.way);
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report_end();
  end

  initial begin
    bit [47:0] a, b, c;
    bit [15:0] pool [6];
    for (int s = 0; s < 64; s++) for (int w = 0; w < 8; w++) begin
      m_val[s][w] = 1'b0; m_tag[s][w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    n_cmp++;
    if (pred_hit !== 1'b0 || pred_way !== 3'd0) begin
      n_bad++;
      $display("FAIL R10 reset: got hit=%0b way=%0d expected hit=0 way=0", pred_hit, pred_way);
    end
    a = mk_addr(16'h1234, 6'd5);
    look(a, "R10");                      // empty table misses
    fill(6'd5, a, 3'd3, "R5");           // installs into LRU way 3
    look(a, "R2");                       // hit way 3
    look(mk_addr(16'h1234, 6'd6), "R4"); // other set misses
    step(1'b0, a, 1'b0, 6'd0, 48'd0, 3'd0, 1'b0, "R9"); // idle lookup
    b = a ^ {20'h0, 16'h8001, 12'h0};    // flips bits 12 and 27: same micro-tag
    look(b, "R1");
    c = a ^ {20'h0, 16'h0001, 12'h0};    // flips bit 12 only
    look(c, "R1");
    c = a ^ {20'h0, 16'h0108, 12'h0};    // flips bits 15 and 20: same micro-tag
    look(c, "R1");
    fill(6'd5, b, 3'd6, "R6");           // matches way 3, LRU ignored
    look(a, "R7");
    c = mk_addr(16'h00F0, 6'd5);
    fill(6'd5, c, 3'd6, "R5");           // new micro-tag into way 6
    look(c, "R2");
    look(a, "R2");
    // R11: lookup and fill collide in set 9
    a = mk_addr(16'h0777, 6'd9);
    step(1'b1, a, 1'b1, 6'd9, a, 3'd1, 1'b0, "R11");
    look(a, "R11");
    // R8: flush wins over simultaneous fill; lookup that cycle sees old contents
    step(1'b1, a, 1'b1, 6'd12, mk_addr(16'h0555, 6'd12), 3'd2, 1'b1, "R8");
    look(a, "R8");
    look(mk_addr(16'h0555, 6'd12), "R8");
    look(mk_addr(16'h00F0, 6'd5), "R8");
    // fill all eight ways of one set, then probe each
    for (int w = 0; w < 8; w++) fill(6'd20, mk_addr(16'(w * 16'h0011 + 16'h0100), 6'd20), 3'(w), "R5");
    for (int w = 0; w < 8; w++) look(mk_addr(16'(w * 16'h0011 + 16'h0100), 6'd20), "R2");
    // random traffic over a small pool of addresses to force matches
    for (int i = 0; i < 6; i++) pool[i] = 16'($urandom);
    pool[5] = pool[0] ^ 16'h8001;
    for (int i = 0; i < 400; i++) begin
      bit [5:0] s;
      s = 6'($urandom_range(0, 3));
      step(1'($urandom), mk_addr(pool[$urandom_range(0, 5)], 6'($urandom_range(0, 3))),
           1'($urandom), s, mk_addr(pool[$urandom_range(0, 5)], s),
           3'($urandom), (i % 97) == 96, "R7");
    end
    step(1'b0, 48'd0, 1'b0, 6'd0, 48'd0, 3'd0, 1'b0, "R9");
    repeat (3) @(negedge clk);
    report_end();
  end
endmodule